// File: doc/BRIEF.md
# Auto-Detecting Parallel Host Bus Slave

This block is the host-side end of an 8-bit parallel bus. It works out by itself which of three bus styles the board uses by watching a single strap-or-strobe pin, the address latch enable. If that pin sits high, the block answers a Motorola-style bus: chip select, a read/write direction line and a data strobe. If it sits low, the block answers an Intel-style bus with separate read and write strobes and a narrow set of address pins. The first transition of the pin in either direction moves the block into multiplexed address/data operation. It stays there until the next hardware reset.

Behind the bus lies a 256-byte register space in four 64-byte regions. The lowest region holds sample input/output, the next holds host/processor communication, and the top two are the register banks of two serial link controllers. The host may reach each of those two banks only while its grant input is high. Host strobes are asynchronous. They are synchronised into the core clock, and every access becomes exactly one internal read or write cycle. An active-low interrupt reports status flags that the core raises and the host masks and clears.

In the two non-multiplexed styles only four address pins exist. Pin address 0xF is therefore a page register that supplies the upper four address bits.

Top module: `hostBusSlave`

## Requirements
- R1: With the latch-enable pin high from reset, the rdN pin acts as read/write direction (1 = read) and wrN acts as data strobe (active low). A cycle with wrN high does nothing, even with rdN low and csN low.
- R2: With the latch-enable pin low from reset, rdN low with csN low is a read, and wrN low with csN low is a write. Both use the address pins.
- R3: Once the detector has settled after reset, any rising or falling transition of the latch-enable pin switches the block to multiplexed mode.
- R4: Multiplexed mode persists until reset, and the address pins are ignored there. After a reset with the latch-enable pin held low, the block is in the demultiplexed Intel style again.
- R5: In multiplexed mode the access address is the value on adIn at the falling edge of the latch-enable pin.
- R6: In the non-multiplexed styles, pin address 0xF reads and writes a 4-bit page register, which resets to 0. Pin addresses 0x0 to 0xE reach byte {page, pin address}.
- R7: Bytes 0x80-0xBF are reachable only while hdlcGrant[0] is 1, and bytes 0xC0-0xFF only while hdlcGrant[1] is 1. A denied write is ignored, and a denied read returns 0x00.
- R8: Each host strobe produces exactly one internal access, however long the strobe is held.
- R9: Byte 0x40 is the status register. statusSet bits set it, and writing 1s clears those bits, with a set winning over a clear in the same cycle. Byte 0x41 is its mask. irqN is low exactly while some status bit and its mask bit are both 1.
- R10: After reset, irqN is 1, adOe is 0 and every register byte reads 0x00.
- R11: adOe is 1 only during a read access with csN low, and never during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| aleIn | input | 1 | Latch-enable pin: static level selects the style, edges select multiplexed mode and latch the address |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, or read/write direction in Motorola style |
| wrN | input | 1 | Write strobe, or data strobe in Motorola style |
| addrIn | input | 4 | Address pins in the non-multiplexed styles |
| adIn | input | 8 | Data in, and address in multiplexed mode |
| adOut | output | 8 | Read data |
| adOe | output | 1 | Read data output enable |
| hdlcGrant | input | 2 | Host access grants for the two link-controller banks |
| statusSet | input | 8 | Per-bit set pulses for the status register |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bench starts the block in each static style and checks that strobe patterns which are legal in the other style are ignored. A wrong style decode would show up as a spurious access or a stray output enable. It enters multiplexed mode through a falling edge in one run and a rising edge in another. It checks that the address pins are then ignored and that only a reset leaves the mode; a block that followed the pin level back would write to the pin address. It writes to denied link-controller banks and reads them back after the grant is given, which catches a write that leaked through. It holds a write strobe on the status register while a new flag arrives, which exposes any design that repeats the clear on every cycle of a long strobe.

// File: rtl/hbiPkg.sv
package hbiPkg;

  typedef enum logic [1:0] {
    BUS_MOTO  = 2'd0,
    BUS_INTEL = 2'd1,
    BUS_MUX   = 2'd2
  } busMode_e;

  typedef struct packed {
    logic rdPulse;
    logic wrPulse;
    logic rdActive;
  } hbiStrobe_t;

endpackage

// File: rtl/hbiModeDetect.sv
module hbiModeDetect
  import hbiPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     aleIn,
  output busMode_e mode,
  output logic     armed
);
  localparam int SettleCycles = SyncStages + 1;
  localparam int CntW = $clog2(SettleCycles + 1);

  logic [SyncStages-1:0] aleSync;
  logic                  alePrev;
  logic [CntW-1:0]       settleCnt;
  logic                  muxSticky;
  busMode_e              levelMode;
  logic                  aleNow;
  logic                  aleEdge;

  assign aleNow  = aleSync[SyncStages-1];
  assign armed   = (settleCnt == CntW'(SettleCycles));
  assign aleEdge = armed && (aleNow ^ alePrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleSync   <= '0;
      alePrev   <= 1'b0;
      settleCnt <= '0;
      muxSticky <= 1'b0;
      levelMode <= BUS_INTEL;
    end else begin
      aleSync <= {aleSync[SyncStages-2:0], aleIn};
      alePrev <= aleNow;
      if (!armed) begin
        settleCnt <= settleCnt + 1'b1;
        levelMode <= aleNow ? BUS_MOTO : BUS_INTEL;
      end
      if (aleEdge) muxSticky <= 1'b1;
    end
  end

  assign mode = muxSticky ? BUS_MUX : levelMode;

endmodule

// File: rtl/hbiCtrl.sv
module hbiCtrl
  import hbiPkg::*;
#(
  parameter int SyncStages = 2,
  parameter int AddrW      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  busMode_e         mode,
  input  logic             armed,
  input  logic             aleIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [AddrW-1:0] adIn,
  output logic [AddrW-1:0] muxAddr,
  output hbiStrobe_t       strobe
);
  logic [SyncStages-1:0] csSync, rdSync, wrSync;
  logic csAct, rdLow, wrLow;
  logic rdActive, wrActive, rdActQ, wrActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      rdSync <= '1;
      wrSync <= '1;
      rdActQ <= 1'b0;
      wrActQ <= 1'b0;
    end else begin
      csSync <= {csSync[SyncStages-2:0], csN};
      rdSync <= {rdSync[SyncStages-2:0], rdN};
      wrSync <= {wrSync[SyncStages-2:0], wrN};
      rdActQ <= rdActive;
      wrActQ <= wrActive;
    end
  end

  // Multiplexed address captured at the trailing edge of the latch enable.
  always_ff @(negedge aleIn or negedge rstN) begin
    if (!rstN) muxAddr <= '0;
    else       muxAddr <= adIn;
  end

  assign csAct = armed && !csSync[SyncStages-1];
  assign rdLow = !rdSync[SyncStages-1];
  assign wrLow = !wrSync[SyncStages-1];

  always_comb begin
    if (mode == BUS_MOTO) begin
      rdActive = csAct && wrLow && !rdLow;
      wrActive = csAct && wrLow && rdLow;
    end else begin
      rdActive = csAct && rdLow;
      wrActive = csAct && wrLow && !rdLow;
    end
  end

  assign strobe.rdActive = rdActive;
  assign strobe.rdPulse  = rdActive && !rdActQ;
  assign strobe.wrPulse  = wrActive && !wrActQ;

endmodule

// File: rtl/hbiDatapath.sv
module hbiDatapath
  import hbiPkg::*;
#(
  parameter int DataW    = 8,
  parameter int AddrW    = 8,
  parameter int PinAddrW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  busMode_e            mode,
  input  hbiStrobe_t          strobe,
  input  logic [PinAddrW-1:0] addrIn,
  input  logic [AddrW-1:0]    muxAddr,
  input  logic [DataW-1:0]    adIn,
  input  logic [1:0]          hdlcGrant,
  input  logic [DataW-1:0]    statusSet,
  output logic [DataW-1:0]    adOut,
  output logic                adOe,
  output logic                irqN
);
  localparam int Depth    = 1 << AddrW;
  localparam int PageW    = AddrW - PinAddrW;
  localparam int RegionW  = 2;
  localparam int Regions  = 1 << RegionW;
  localparam int HdlcBase = Regions - 2;
  localparam logic [AddrW-1:0]    StatusAddr = AddrW'(Depth / Regions);
  localparam logic [AddrW-1:0]    MaskAddr   = StatusAddr + 1'b1;
  localparam logic [PinAddrW-1:0] PagePin    = '1;

  logic [DataW-1:0]   mem [Depth];
  logic [PageW-1:0]   pageQ;
  logic [DataW-1:0]   statusQ, maskQ, rdDataQ, clrMask;
  logic [AddrW-1:0]   effAddr;
  logic [RegionW-1:0] region;
  logic [Regions-1:0] regionOk;
  logic               isMux, pageHit, granted, hitStatus, hitMask;

  for (genvar g = 0; g < Regions; g++) begin : g_region
    if (g < HdlcBase) begin : g_open
      assign regionOk[g] = 1'b1;
    end else begin : g_gated
      assign regionOk[g] = hdlcGrant[g-HdlcBase];
    end
  end

  assign isMux     = (mode == BUS_MUX);
  assign pageHit   = !isMux && (addrIn == PagePin);
  assign effAddr   = isMux ? muxAddr : {pageQ, addrIn};
  assign region    = effAddr[AddrW-1 -: RegionW];
  assign granted   = regionOk[region];
  assign hitStatus = !pageHit && (effAddr == StatusAddr);
  assign hitMask   = !pageHit && (effAddr == MaskAddr);
  assign clrMask   = (strobe.wrPulse && hitStatus) ? adIn : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < Depth; i++) mem[i] <= '0;
      pageQ   <= '0;
      statusQ <= '0;
      maskQ   <= '0;
      rdDataQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | statusSet;
      if (strobe.wrPulse) begin
        if (pageHit)       pageQ <= adIn[PageW-1:0];
        else if (hitMask)  maskQ <= adIn;
        else if (!hitStatus && granted) mem[effAddr] <= adIn;
      end
      if (strobe.rdPulse) begin
        if (pageHit)        rdDataQ <= DataW'(pageQ);
        else if (hitStatus) rdDataQ <= statusQ;
        else if (hitMask)   rdDataQ <= maskQ;
        else if (granted)   rdDataQ <= mem[effAddr];
        else                rdDataQ <= '0;
      end
    end
  end

  assign adOut = rdDataQ;
  assign adOe  = strobe.rdActive;
  assign irqN  = ~|(statusQ & maskQ);

endmodule

// File: rtl/hostBusSlave.sv
module hostBusSlave
  import hbiPkg::*;
#(
  parameter int DataW      = 8,
  parameter int AddrW      = 8,
  parameter int PinAddrW   = 4,
  parameter int SyncStages = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                aleIn,
  input  logic                csN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic [PinAddrW-1:0] addrIn,
  input  logic [DataW-1:0]    adIn,
  output logic [DataW-1:0]    adOut,
  output logic                adOe,
  input  logic [1:0]          hdlcGrant,
  input  logic [DataW-1:0]    statusSet,
  output logic                irqN
);
  busMode_e         busMode;
  logic             armed;
  hbiStrobe_t       strb;
  logic [AddrW-1:0] muxAddr;

  hbiModeDetect #(.SyncStages(SyncStages)) u_mode (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .mode(busMode), .armed(armed)
  );

  hbiCtrl #(.SyncStages(SyncStages), .AddrW(AddrW)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(busMode), .armed(armed), .aleIn(aleIn),
    .csN(csN), .rdN(rdN), .wrN(wrN), .adIn(adIn[AddrW-1:0]),
    .muxAddr(muxAddr), .strobe(strb)
  );

  hbiDatapath #(.DataW(DataW), .AddrW(AddrW), .PinAddrW(PinAddrW)) u_dp (
    .clk(clk), .rstN(rstN), .mode(busMode), .strobe(strb), .addrIn(addrIn),
    .muxAddr(muxAddr), .adIn(adIn), .hdlcGrant(hdlcGrant),
    .statusSet(statusSet), .adOut(adOut), .adOe(adOe), .irqN(irqN)
  );

endmodule

// File: rtl/hostBusSlaveChk.sv
module hostBusSlaveChk
  import hbiPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       adOe,
  input logic       irqN,
  input logic [1:0] mode,
  input logic       armed,
  input logic       rdPulse,
  input logic       wrPulse
);
  // R11: output enable only follows a selected chip (two sync stages back)
  p_oe_needs_cs_r11: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> !$past(csN, 2));

  // R11: never drive during a write cycle
  p_no_oe_on_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> !adOe);

  // R8: one internal write per strobe
  p_one_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  // R2: read and write never issued together
  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPulse && wrPulse));

  // R4: multiplexed mode is sticky
  p_mux_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == BUS_MUX) |=> (mode == BUS_MUX));

  // R3: after settling, the only mode change is into multiplexed mode
  p_mode_only_to_mux_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(armed) && (mode != $past(mode))) |-> (mode == BUS_MUX));

  // R9: interrupt releases only after a host write
  p_irq_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> $past(wrPulse));

endmodule

bind hostBusSlave hostBusSlaveChk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .adOe(adOe), .irqN(irqN),
  .mode(busMode), .armed(armed), .rdPulse(strb.rdPulse), .wrPulse(strb.wrPulse)
);

// File: tb/hostBusSlave_bench.sv
module hostBusSlave_bench;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 60000;

  // {addr, wdata, grant, expected read}
  localparam logic [25:0] Vecs [0:7] = '{
    {8'h05, 8'h3C, 2'b00, 8'h3C},
    {8'h7E, 8'hA5, 2'b00, 8'hA5},
    {8'h80, 8'h11, 2'b00, 8'h00},
    {8'h81, 8'h22, 2'b01, 8'h22},
    {8'hC0, 8'h33, 2'b01, 8'h00},
    {8'hFF, 8'h44, 2'b10, 8'h44},
    {8'hBF, 8'h55, 2'b10, 8'h00},
    {8'h3F, 8'hFF, 2'b11, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aleIn = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [3:0] addrIn = '0;
  logic [7:0] adIn = '0, adOut, statusSet = '0;
  logic [1:0] hdlcGrant = '0;
  logic adOe, irqN;
  logic [7:0] got;
  int nChk = 0, nFail = 0;

  always #(ClkPeriod/2) clk = ~clk;

  hostBusSlave u_hostBusSlave (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addrIn(addrIn), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .hdlcGrant(hdlcGrant), .statusSet(statusSet), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic aleLvl);
    @(negedge clk);
    aleIn = aleLvl; csN = 1; rdN = 1; wrN = 1; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulseSet(input logic [7:0] v);
    @(negedge clk); statusSet = v;
    @(negedge clk); statusSet = '0;
  endtask

  // Intel style (also used with pin strobes in multiplexed mode)
  task automatic intelWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addrIn = a; adIn = d; csN = 0;
    @(negedge clk); wrN = 0;
    repeat (6) @(negedge clk);
    wrN = 1;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic intelRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addrIn = a; csN = 0;
    @(negedge clk); rdN = 0;
    repeat (6) @(negedge clk);
    d = adOe ? adOut : 8'hXX;
    rdN = 1;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic motoWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addrIn = a; adIn = d; rdN = 0; csN = 0;
    @(negedge clk); wrN = 0;
    repeat (6) @(negedge clk);
    wrN = 1;
    @(negedge clk); rdN = 1; csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic motoRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addrIn = a; rdN = 1; csN = 0;
    @(negedge clk); wrN = 0;
    repeat (6) @(negedge clk);
    d = adOe ? adOut : 8'hXX;
    wrN = 1;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic aleAddr(input logic [7:0] a);
    @(negedge clk); adIn = a; aleIn = 1;
    repeat (2) @(negedge clk);
    aleIn = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic muxWrite(input logic [7:0] a, input logic [7:0] d);
    aleAddr(a);
    adIn = d; csN = 0;
    @(negedge clk); wrN = 0;
    repeat (6) @(negedge clk);
    wrN = 1;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic muxRead(input logic [7:0] a, output logic [7:0] d);
    aleAddr(a);
    csN = 0;
    @(negedge clk); rdN = 0;
    repeat (6) @(negedge clk);
    d = adOe ? adOut : 8'hXX;
    rdN = 1;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    // ---------- Intel demultiplexed style ----------
    doReset(1'b0);
    check("R10 irqN after reset", {7'b0, irqN}, 8'h01);
    check("R10 adOe after reset", {7'b0, adOe}, 8'h00);
    intelRead(4'h5, got); check("R10 register cleared", got, 8'h00);
    intelWrite(4'h2, 8'hA7);
    intelRead(4'h3, got); check("R2 neighbour untouched", got, 8'h00);
    intelRead(4'h2, got); check("R2 read back", got, 8'hA7);
    // R11: read strobe without chip select
    @(negedge clk); rdN = 0;
    repeat (6) @(negedge clk);
    check("R11 no enable without cs", {7'b0, adOe}, 8'h00);
    rdN = 1; repeat (3) @(negedge clk);
    // page 4 reaches status (pin 0) and mask (pin 1)
    intelWrite(4'hF, 8'h04);
    intelRead(4'hF, got); check("R6 page readback", got, 8'h04);
    intelWrite(4'h1, 8'h05);
    pulseSet(8'h02); @(negedge clk);
    check("R9 masked flag no irq", {7'b0, irqN}, 8'h01);
    pulseSet(8'h04); @(negedge clk);
    check("R9 enabled flag irq", {7'b0, irqN}, 8'h00);
    intelRead(4'h0, got); check("R9 status value", got, 8'h06);
    intelWrite(4'h0, 8'h04);
    check("R9 irq released", {7'b0, irqN}, 8'h01);
    intelRead(4'h0, got); check("R9 status after clear", got, 8'h02);
    // R8: long write strobe clearing bit0 while bit0 is raised again mid-strobe
    pulseSet(8'h01);
    @(negedge clk); addrIn = 4'h0; adIn = 8'h01; csN = 0;
    @(negedge clk); wrN = 0;
    repeat (6) @(negedge clk);
    statusSet = 8'h01;
    @(negedge clk); statusSet = 8'h00;
    repeat (2) @(negedge clk);
    wrN = 1;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
    intelRead(4'h0, got); check("R8 single clear per strobe", got, 8'h03);

    // ---------- Motorola style ----------
    doReset(1'b1);
    motoWrite(4'hF, 8'h07);
    motoWrite(4'h5, 8'hC3);
    motoRead(4'h5, got); check("R1 read back", got, 8'hC3);
    motoRead(4'hF, got); check("R6 page in moto", got, 8'h07);
    // R1: Intel-style read pattern must do nothing
    @(negedge clk); addrIn = 4'h5; csN = 0;
    @(negedge clk); rdN = 0;
    repeat (6) @(negedge clk);
    check("R1 no access without data strobe", {7'b0, adOe}, 8'h00);
    rdN = 1; @(negedge clk); csN = 1; repeat (3) @(negedge clk);

    // ---------- multiplexed via falling edge ----------
    muxRead(8'h75, got); check("R3 falling edge, R6 page map, R5", got, 8'hC3);
    for (int i = 0; i < 8; i++) begin
      hdlcGrant = Vecs[i][9:8];
      muxWrite(Vecs[i][25:18], Vecs[i][17:10]);
      muxRead(Vecs[i][25:18], got);
      check("R7 R5 vector", got, Vecs[i][7:0]);
    end
    hdlcGrant = 2'b11;
    muxRead(8'h80, got); check("R7 denied write ignored", got, 8'h00);
    // pins ignored: write lands at latched 0x80
    intelWrite(4'h2, 8'h66);
    muxRead(8'h80, got); check("R4 latched address used", got, 8'h66);
    muxRead(8'h02, got); check("R4 pins ignored", got, 8'h00);

    // ---------- reset back, then rising edge ----------
    doReset(1'b0);
    hdlcGrant = 2'b00;
    intelWrite(4'h2, 8'h77);
    intelRead(4'h3, got); check("R4 demux after reset", got, 8'h00);
    intelRead(4'h2, got); check("R4 demux readback", got, 8'h77);
    addrIn = 4'h2;
    muxWrite(8'h10, 8'h5A);
    muxRead(8'h10, got); check("R3 rising edge enters mux", got, 8'h5A);

    finishRun();
  end
endmodule